// File: doc/BRIEF.md
# UART Host Register and Interrupt Controller

This block is the host-side register front end of a UART whose character FIFOs hold up to sixteen entries each. A word-addressed bus reaches five registers: a data port, a control word, a baud word, a write-only command word and a read-only status word. The serial engines, the FIFOs and the baud divider sit outside the block. They are connected through plain signals: FIFO counts, the receive head byte, event pulses, a bit-time tick, and outgoing push, pull and flush strobes.

Six sticky flags live here: receive-ready, overrun, break, framing error and parity error on the receive side, and transmit-ready on the transmit side. Software changes a flag only through the command word, which has one bit to set and one bit to clear for every flag. Receive data is never popped as a side effect of a read. Software must first issue a pull command, and the new head byte can then be read from the data port.

Receive-ready is raised a programmable number of bit times after a character arrives. Transmit-ready is raised when the transmit FIFO fill drops to or below a programmable threshold. A single registered interrupt line combines the flags with per-flag enable bits.

Top module: `uart_host_regs`

## Requirements
- R1: While reset is held and in the first cycle after it, read data, the interrupt, every strobe and every configuration output are 0.
- R2: The control word (word index 1) keeps bits 25:0 and reads bits 31:26 as 0. Its fields are:
  - bits 5:0: interrupt enables for receive-ready, overrun, break, framing, parity and transmit-ready;
  - bits 8:6: word length;
  - bit 9: parity enable;
  - bit 10: even parity;
  - bit 11: two stop bits;
  - bit 12: hardware handshake;
  - bit 13: force break;
  - bits 21:14: receive-ready delay;
  - bits 25:22: transmit threshold.
  The single-bit and word-length fields appear on the configuration outputs one cycle after the write.
- R3: The baud word (word index 2) keeps bits 15:0. It drives the mantissa from bits 11:0 and the exponent from bits 15:12, and reads bits 31:16 as 0.
- R4: A write to the data port (word index 0) produces a one-cycle transmit push in the same cycle, carrying bits 7:0. A read of the data port returns the receive head byte in bits 7:0.
- R5: Command-word (word index 3) bit 10 pulls one receive character, bit 11 flushes the receive FIFO and bit 12 flushes the transmit FIFO. Each is a strobe in the same cycle as the write.
- R6: Overrun, break, framing and parity event pulses set sticky flags. Status (word index 4) reports:
  - bit 0: receive-ready;
  - bit 1: transmit-ready;
  - bit 2: overrun;
  - bit 3: break;
  - bit 4: framing error;
  - bit 5: parity error;
  - bits 10:6: receive count;
  - bits 15:11: transmit count.
- R7: Command bits 0 to 4 clear receive-ready, overrun, break, framing and parity. Bits 5 to 9 set the same flags. Bit 13 clears transmit-ready and bit 14 sets it.
- R8: When a flag's set and clear arrive in the same cycle, the set wins. This holds whether the set comes from software or from a hardware event.
- R9: With a delay of 0, receive-ready is set two clock edges after the arrival pulse. With a delay of D, it is set one edge after the D-th bit tick that follows the arrival.
- R10: Transmit-ready is set on the cycle the transmit count first becomes less than or equal to the threshold. While that condition simply stays true, the flag is not set again.
- R11: The interrupt is the registered OR of every flag ANDed with its enable bit.
- R12: Reads of the command word and of word indices 5 to 7 return 0. Writes to the status word or to an unused index change no register and no flag.
- R13: A receive flush cancels a pending receive-ready delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe, data valid one cycle later |
| bus_addr_i | input | ADDR_W | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| rx_head_i | input | CHAR_W | Byte at the head of the receive FIFO |
| rx_count_i | input | CNT_W | Receive FIFO fill |
| tx_count_i | input | CNT_W | Transmit FIFO fill |
| rx_char_i | input | 1 | Pulse: a character entered the receive FIFO |
| bit_tick_i | input | 1 | Pulse: one bit time elapsed |
| rx_overrun_i | input | 1 | Pulse: receive overrun |
| rx_break_i | input | 1 | Pulse: break detected |
| rx_frame_err_i | input | 1 | Pulse: framing error |
| rx_parity_err_i | input | 1 | Pulse: parity error |
| rx_pull_o | output | 1 | Pop one receive character |
| rx_flush_o | output | 1 | Empty the receive FIFO |
| tx_flush_o | output | 1 | Empty the transmit FIFO |
| tx_push_o | output | 1 | Push a byte into the transmit FIFO |
| tx_byte_o | output | CHAR_W | Byte to push |
| cfg_wlen_o | output | 3 | Word length code |
| cfg_par_en_o | output | 1 | Parity enable |
| cfg_par_even_o | output | 1 | Even parity |
| cfg_stop2_o | output | 1 | Two stop bits |
| cfg_hs_en_o | output | 1 | Hardware handshake enable |
| cfg_brk_o | output | 1 | Force transmit line low |
| baud_mant_o | output | 12 | Baud mantissa |
| baud_exp_o | output | 4 | Baud exponent |

## Verification
The bench targets the same-cycle collisions between set and clear. A design that let the clear win would lose an overrun that lands together with a software clear, and the status would show the flag low. It also checks that transmit-ready keeps its software clear while the FIFO simply stays below the threshold; a level-sensitive version would set the flag again at once. The receive-ready delay is checked one bit tick before it expires and again after it expires, and again after a flush in mid-count, which would expose an off-by-one count or a timer the flush does not cancel. The bench also checks the interrupt enable order and confirms that writes to the status word and unused indices leave every register unchanged.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
// Shared constants for the UART host register block.
// Assumes a 32-bit bus word; bit positions below are the software contract.
package uart_regs_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_FLAGS = 6;
    localparam int DLY_W     = 8;
    localparam int THR_W     = 4;
    localparam int BAUD_W    = 16;
    localparam int MANT_W    = 12;
    localparam int EXP_W     = BAUD_W - MANT_W;

    // Word indices of the registers.
    typedef enum logic [2:0] {
        RSEL_DATA   = 3'd0,
        RSEL_CTRL   = 3'd1,
        RSEL_BAUD   = 3'd2,
        RSEL_CMD    = 3'd3,
        RSEL_STATUS = 3'd4
    } reg_sel_e;

    // Flag indices, equal to their status bit positions.
    localparam int FL_RRDY = 0;
    localparam int FL_TRDY = 1;
    localparam int FL_OE   = 2;
    localparam int FL_BRK  = 3;
    localparam int FL_FE   = 4;
    localparam int FL_PE   = 5;

    // Control word layout.
    localparam int CTL_WLEN_LSB = 6;
    localparam int CTL_WLEN_W   = 3;
    localparam int CTL_PAR_EN   = 9;
    localparam int CTL_PAR_EVEN = 10;
    localparam int CTL_STOP2    = 11;
    localparam int CTL_HS_EN    = 12;
    localparam int CTL_BRK      = 13;
    localparam int CTL_DLY_LSB  = 14;
    localparam int CTL_THR_LSB  = CTL_DLY_LSB + DLY_W;
    localparam int CTL_USED_W   = CTL_THR_LSB + THR_W;

    // Per-flag positions (indexed by flag index): enable, clear command, set command.
    localparam int IE_POS  [NUM_FLAGS] = '{0, 5, 1, 2, 3, 4};
    localparam int CLR_POS [NUM_FLAGS] = '{0, 13, 1, 2, 3, 4};
    localparam int SET_POS [NUM_FLAGS] = '{5, 14, 6, 7, 8, 9};

    // Command strobes.
    localparam int CMD_RX_PULL  = 10;
    localparam int CMD_RX_FLUSH = 11;
    localparam int CMD_TX_FLUSH = 12;

endpackage

// File: rtl/uart_cfg_regs.sv
`timescale 1ns/1ps
// Holds the control and baud words.
// Assumes the caller has already decoded the write enables; holds no other state.
module uart_cfg_regs
    import uart_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we_i,
    input  logic                  baud_we_i,
    input  logic [CTL_USED_W-1:0] ctrl_wdata_i,
    input  logic [BAUD_W-1:0]     baud_wdata_i,
    output logic [CTL_USED_W-1:0] ctrl_o,
    output logic [BAUD_W-1:0]     baud_o
);

    logic [CTL_USED_W-1:0] ctrl_q;
    logic [BAUD_W-1:0]     baud_q;

    // Capture the control word on its write.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
    end

    // Capture the baud word on its write.
    always_ff @(posedge clk) begin
        if (!rst_n)         baud_q <= '0;
        else if (baud_we_i) baud_q <= baud_wdata_i;
    end

    assign ctrl_o = ctrl_q;
    assign baud_o = baud_q;

    a_r2_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we_i |=> $stable(ctrl_o));
    a_r3_baud_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_we_i |=> $stable(baud_o));

endmodule

// File: rtl/uart_flag_bank.sv
`timescale 1ns/1ps
// A bank of sticky flags, each with a set request and a clear request.
// Assumes set requests already merge hardware and software sources; set beats clear.
module uart_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[g] <= 1'b0;
            else if (set_i[g]) flag_q[g] <= 1'b1;
            else if (clr_i[g]) flag_q[g] <= 1'b0;
        end

        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_o[g]);
        a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !clr_i[g]) |=> $stable(flags_o[g]));
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/uart_rdy_delay.sv
`timescale 1ns/1ps
// Delays receive-ready by a programmed number of bit ticks after a character arrives.
// Assumes one tick per bit time; further arrivals while armed do not restart the count.
module uart_rdy_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_i,
    input  logic          tick_i,
    input  logic          cancel_i,
    input  logic [DW-1:0] dly_i,
    output logic          fire_o
);

    logic          armed_q;
    logic [DW-1:0] cnt_q;
    logic          fire_q;
    logic [DW-1:0] cnt_next;

    assign cnt_next = cnt_q + 1'b1;

    // Arm on arrival, count ticks, pulse fire when the count matches the delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (cancel_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (!armed_q) begin
                if (char_i) begin
                    if (dly_i == '0) begin
                        fire_q <= 1'b1;
                    end else begin
                        armed_q <= 1'b1;
                        cnt_q   <= '0;
                    end
                end
            end else if (tick_i) begin
                cnt_q <= cnt_next;
                if (cnt_next == dly_i) begin
                    fire_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign fire_o = fire_q;

    a_r13_cancel_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> (!armed_q && !fire_o));
    a_r9_fire_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(char_i || (armed_q && tick_i)));
    a_r9_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

endmodule

// File: rtl/uart_host_regs.sv
`timescale 1ns/1ps
// Host register front end of a UART: decodes the bus, keeps the sticky flags,
// raises the interrupt, and issues the FIFO strobes. Assumes CNT_W >= THR_W and
// that event inputs are single-cycle pulses. Read data appears one cycle after bus_rd_i.
module uart_host_regs
    import uart_regs_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [WORD_W-1:0]   bus_wdata_i,
    output logic [WORD_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    input  logic [CHAR_W-1:0]   rx_head_i,
    input  logic [CNT_W-1:0]    rx_count_i,
    input  logic [CNT_W-1:0]    tx_count_i,
    input  logic                rx_char_i,
    input  logic                bit_tick_i,
    input  logic                rx_overrun_i,
    input  logic                rx_break_i,
    input  logic                rx_frame_err_i,
    input  logic                rx_parity_err_i,
    output logic                rx_pull_o,
    output logic                rx_flush_o,
    output logic                tx_flush_o,
    output logic                tx_push_o,
    output logic [CHAR_W-1:0]   tx_byte_o,
    output logic [CTL_WLEN_W-1:0] cfg_wlen_o,
    output logic                cfg_par_en_o,
    output logic                cfg_par_even_o,
    output logic                cfg_stop2_o,
    output logic                cfg_hs_en_o,
    output logic                cfg_brk_o,
    output logic [MANT_W-1:0]   baud_mant_o,
    output logic [EXP_W-1:0]    baud_exp_o
);

    localparam int STAT_USED_W = NUM_FLAGS + 2 * CNT_W;

    logic [CTL_USED_W-1:0] ctrl;
    logic [BAUD_W-1:0]     baud;
    logic [NUM_FLAGS-1:0]  flags;
    logic [NUM_FLAGS-1:0]  hw_set;
    logic [NUM_FLAGS-1:0]  sw_set;
    logic [NUM_FLAGS-1:0]  sw_clr;
    logic [NUM_FLAGS-1:0]  irq_en;
    logic                  sel_data, sel_ctrl, sel_baud, sel_cmd;
    logic                  cmd_we;
    logic                  rdy_fire;
    logic                  tx_below, tx_below_q;
    logic [THR_W-1:0]      tx_thr;
    logic [DLY_W-1:0]      rx_dly;
    logic [WORD_W-1:0]     rd_mux;
    logic [WORD_W-1:0]     rdata_q;
    logic                  irq_q;
    logic                  unused_wdata_top;

    assign unused_wdata_top = ^bus_wdata_i[WORD_W-1:CTL_USED_W];

    // Decode the word index.
    always_comb begin
        sel_data = (bus_addr_i == ADDR_W'(RSEL_DATA));
        sel_ctrl = (bus_addr_i == ADDR_W'(RSEL_CTRL));
        sel_baud = (bus_addr_i == ADDR_W'(RSEL_BAUD));
        sel_cmd  = (bus_addr_i == ADDR_W'(RSEL_CMD));
    end

    assign cmd_we = bus_wr_i && sel_cmd;

    uart_cfg_regs i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we_i    (bus_wr_i && sel_ctrl),
        .baud_we_i    (bus_wr_i && sel_baud),
        .ctrl_wdata_i (bus_wdata_i[CTL_USED_W-1:0]),
        .baud_wdata_i (bus_wdata_i[BAUD_W-1:0]),
        .ctrl_o       (ctrl),
        .baud_o       (baud)
    );

    // Configuration fields.
    assign cfg_wlen_o     = ctrl[CTL_WLEN_LSB +: CTL_WLEN_W];
    assign cfg_par_en_o   = ctrl[CTL_PAR_EN];
    assign cfg_par_even_o = ctrl[CTL_PAR_EVEN];
    assign cfg_stop2_o    = ctrl[CTL_STOP2];
    assign cfg_hs_en_o    = ctrl[CTL_HS_EN];
    assign cfg_brk_o      = ctrl[CTL_BRK];
    assign rx_dly         = ctrl[CTL_DLY_LSB +: DLY_W];
    assign tx_thr         = ctrl[CTL_THR_LSB +: THR_W];
    assign baud_mant_o    = baud[MANT_W-1:0];
    assign baud_exp_o     = baud[BAUD_W-1:MANT_W];

    // Command strobes and data push act in the write cycle.
    assign rx_pull_o  = cmd_we && bus_wdata_i[CMD_RX_PULL];
    assign rx_flush_o = cmd_we && bus_wdata_i[CMD_RX_FLUSH];
    assign tx_flush_o = cmd_we && bus_wdata_i[CMD_TX_FLUSH];
    assign tx_push_o  = bus_wr_i && sel_data;
    assign tx_byte_o  = bus_wdata_i[CHAR_W-1:0];

    uart_rdy_delay #(.DW(DLY_W)) i_rdy_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_i   (rx_char_i),
        .tick_i   (bit_tick_i),
        .cancel_i (rx_flush_o),
        .dly_i    (rx_dly),
        .fire_o   (rdy_fire)
    );

    // Transmit fill compared with the threshold.
    assign tx_below = (tx_count_i <= CNT_W'(tx_thr));

    // Remember the previous comparison to find its entry edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_below_q <= 1'b0;
        else        tx_below_q <= tx_below;
    end

    // Hardware set sources per flag.
    always_comb begin
        hw_set          = '0;
        hw_set[FL_RRDY] = rdy_fire;
        hw_set[FL_TRDY] = tx_below && !tx_below_q;
        hw_set[FL_OE]   = rx_overrun_i;
        hw_set[FL_BRK]  = rx_break_i;
        hw_set[FL_FE]   = rx_frame_err_i;
        hw_set[FL_PE]   = rx_parity_err_i;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cmd
        assign sw_set[g] = cmd_we && bus_wdata_i[SET_POS[g]];
        assign sw_clr[g] = cmd_we && bus_wdata_i[CLR_POS[g]];
        assign irq_en[g] = ctrl[IE_POS[g]];
    end

    uart_flag_bank #(.N(NUM_FLAGS)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (hw_set | sw_set),
        .clr_i   (sw_clr),
        .flags_o (flags)
    );

    // Read data selection.
    always_comb begin
        unique case (bus_addr_i)
            ADDR_W'(RSEL_DATA):   rd_mux = WORD_W'(rx_head_i);
            ADDR_W'(RSEL_CTRL):   rd_mux = WORD_W'(ctrl);
            ADDR_W'(RSEL_BAUD):   rd_mux = WORD_W'(baud);
            ADDR_W'(RSEL_STATUS): rd_mux = WORD_W'({tx_count_i, rx_count_i, flags});
            default:              rd_mux = '0;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_mux;
    end

    // Register the combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags & irq_en);
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = irq_q;

    a_r11_irq_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & irq_en)) |=> irq_o);
    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |=> !irq_o);
    a_r10_trdy_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_below) |=> flags[FL_TRDY]);
    a_r12_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !sel_ctrl && !sel_baud) |=> ($stable(cfg_wlen_o) && $stable(baud_mant_o)));
    a_r5_push_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pull_o |-> !tx_push_o);
    a_r12_width_ok: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (STAT_USED_W <= WORD_W));

endmodule

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  rx_head = '0;
    logic [4:0]  rx_count = '0, tx_count = '0;
    logic        rx_char = 1'b0, bit_tick = 1'b0;
    logic        ev_oe = 1'b0, ev_brk = 1'b0, ev_fe = 1'b0, ev_pe = 1'b0;
    logic        rx_pull, rx_flush, tx_flush, tx_push;
    logic [7:0]  tx_byte;
    logic [2:0]  wlen;
    logic        par_en, par_even, stop2, hs_en, brk;
    logic [11:0] mant;
    logic [3:0]  bexp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic s_pull, s_rxf, s_txf, s_push;
    logic [7:0] s_byte;
    logic [31:0] rv;

    always #5 clk = ~clk;

    uart_host_regs i_uart_host_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
        .rx_head_i(rx_head), .rx_count_i(rx_count), .tx_count_i(tx_count),
        .rx_char_i(rx_char), .bit_tick_i(bit_tick),
        .rx_overrun_i(ev_oe), .rx_break_i(ev_brk), .rx_frame_err_i(ev_fe),
        .rx_parity_err_i(ev_pe),
        .rx_pull_o(rx_pull), .rx_flush_o(rx_flush), .tx_flush_o(tx_flush),
        .tx_push_o(tx_push), .tx_byte_o(tx_byte),
        .cfg_wlen_o(wlen), .cfg_par_en_o(par_en), .cfg_par_even_o(par_even),
        .cfg_stop2_o(stop2), .cfg_hs_en_o(hs_en), .cfg_brk_o(brk),
        .baud_mant_o(mant), .baud_exp_o(bexp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        s_pull = rx_pull; s_rxf = rx_flush; s_txf = tx_flush;
        s_push = tx_push; s_byte = tx_byte;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 cfg", {wlen, par_en, par_even, stop2, hs_en, brk, mant, bexp}, 0);
        chk("R1 strobes", {rx_pull, rx_flush, tx_flush, tx_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle irq", {31'b0, irq}, 0);
    endtask

    task automatic t_ctrl();
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, rv);
        chk("R2 readback mask", rv, 32'h03FF_FFFF);
        wr(3'd1, 32'h0000_2A80);
        chk("R2 fields", {29'b0, wlen}, 2);
        chk("R2 singles", {26'b0, par_en, par_even, stop2, hs_en, brk}, 5'b10101);
        wr(3'd1, 32'h0000_1400);
        chk("R2 even/hs", {27'b0, par_en, par_even, stop2, hs_en, brk}, 5'b01010);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_baud();
        wr(3'd2, 32'hFFFF_5ABC);
        rd(3'd2, rv);
        chk("R3 readback", rv, 32'h0000_5ABC);
        chk("R3 mant/exp", {16'b0, bexp, mant}, 32'h5ABC);
    endtask

    task automatic t_data();
        rx_head = 8'hA5;
        rd(3'd0, rv);
        chk("R4 data read", rv, 32'hA5);
        wr(3'd0, 32'h1234_5637);
        chk("R4 push", {23'b0, s_push, s_byte}, {23'b0, 1'b1, 8'h37});
        #1 chk("R4 push one cycle", {31'b0, tx_push}, 0);
    endtask

    task automatic t_cmd_strobes();
        wr(3'd3, 32'h400);
        chk("R5 pull", {28'b0, s_pull, s_rxf, s_txf, s_push}, 4'b1000);
        wr(3'd3, 32'h800);
        chk("R5 rx flush", {28'b0, s_pull, s_rxf, s_txf, s_push}, 4'b0100);
        wr(3'd3, 32'h1000);
        chk("R5 tx flush", {28'b0, s_pull, s_rxf, s_txf, s_push}, 4'b0010);
        #1 chk("R5 strobes drop", {29'b0, rx_pull, rx_flush, tx_flush}, 0);
    endtask

    task automatic ev(input int which);
        @(negedge clk);
        case (which)
            0: ev_oe = 1'b1;
            1: ev_brk = 1'b1;
            2: ev_fe = 1'b1;
            default: ev_pe = 1'b1;
        endcase
        @(negedge clk);
        ev_oe = 1'b0; ev_brk = 1'b0; ev_fe = 1'b0; ev_pe = 1'b0;
    endtask

    task automatic t_flags();
        wr(3'd3, 32'h201F);
        rd(3'd4, rv); chk("R7 all cleared", rv & 32'h3F, 0);
        ev(0); rd(3'd4, rv); chk("R6 overrun bit2", rv & 32'h3F, 32'h04);
        ev(1); rd(3'd4, rv); chk("R6 break bit3", rv & 32'h3F, 32'h0C);
        ev(2); rd(3'd4, rv); chk("R6 framing bit4", rv & 32'h3F, 32'h1C);
        ev(3); rd(3'd4, rv); chk("R6 parity bit5", rv & 32'h3F, 32'h3C);
        idle(3); rd(3'd4, rv); chk("R6 sticky", rv & 32'h3F, 32'h3C);
        wr(3'd3, 32'h2); rd(3'd4, rv); chk("R7 clear overrun", rv & 32'h3F, 32'h38);
        wr(3'd3, 32'h1F); rd(3'd4, rv); chk("R7 clear rx flags", rv & 32'h3F, 0);
        wr(3'd3, 32'h3E0); rd(3'd4, rv); chk("R7 set rx flags", rv & 32'h3F, 32'h3D);
        wr(3'd3, 32'h4000); rd(3'd4, rv); chk("R7 set trdy", rv & 32'h3F, 32'h3F);
        wr(3'd3, 32'h2000); rd(3'd4, rv); chk("R7 clear trdy", rv & 32'h3F, 32'h3D);
        wr(3'd3, 32'h201F);
    endtask

    task automatic t_set_wins();
        wr(3'd3, 32'h21);
        rd(3'd4, rv); chk("R8 sw set beats clear", rv & 32'h3F, 32'h01);
        wr(3'd3, 32'h1);
        @(negedge clk);
        ev_oe = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h2;
        @(negedge clk);
        ev_oe = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(3'd4, rv); chk("R8 hw set beats clear", rv & 32'h3F, 32'h04);
        wr(3'd3, 32'h201F);
    endtask

    task automatic t_rdy_delay();
        @(negedge clk); rx_char = 1'b1;
        @(negedge clk); rx_char = 1'b0;
        idle(1);
        rd(3'd4, rv); chk("R9 zero delay", rv & 32'h1, 1);
        wr(3'd3, 32'h1);
        wr(3'd1, 32'h0000_C000);
        @(negedge clk); rx_char = 1'b1;
        @(negedge clk); rx_char = 1'b0;
        pulse_tick(); pulse_tick(); idle(1);
        rd(3'd4, rv); chk("R9 before last tick", rv & 32'h1, 0);
        pulse_tick(); idle(1);
        rd(3'd4, rv); chk("R9 after third tick", rv & 32'h1, 1);
        wr(3'd3, 32'h1);
    endtask

    task automatic t_cancel();
        @(negedge clk); rx_char = 1'b1;
        @(negedge clk); rx_char = 1'b0;
        pulse_tick(); pulse_tick();
        wr(3'd3, 32'h800);
        pulse_tick(); pulse_tick(); pulse_tick(); idle(1);
        rd(3'd4, rv); chk("R13 flush cancels delay", rv & 32'h1, 0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_trdy();
        wr(3'd3, 32'h2000);
        rd(3'd4, rv); chk("R10 no re-set while below", rv & 32'h2, 0);
        wr(3'd1, 32'h0080_0000);
        rx_count = 5'd9; tx_count = 5'd16;
        idle(2);
        rd(3'd4, rv); chk("R6 fill fields", rv >> 6, (32'd16 << 5) | 32'd9);
        chk("R10 above threshold", rv & 32'h2, 0);
        tx_count = 5'd2;
        idle(2);
        rd(3'd4, rv); chk("R10 entry at threshold", rv & 32'h2, 32'h2);
        tx_count = 5'd0; rx_count = 5'd0;
    endtask

    task automatic t_irq();
        wr(3'd3, 32'h201F);
        wr(3'd1, 32'h20);
        idle(1); chk("R11 no flag no irq", {31'b0, irq}, 0);
        wr(3'd3, 32'h4000);
        idle(1); chk("R11 trdy enabled irq", {31'b0, irq}, 1);
        wr(3'd1, 32'h02);
        idle(1); chk("R11 trdy not enabled", {31'b0, irq}, 0);
        ev(0);
        idle(1); chk("R11 overrun enabled irq", {31'b0, irq}, 1);
    endtask

    task automatic t_ro();
        rd(3'd3, rv); chk("R12 cmd reads zero", rv, 0);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), rv); chk("R12 unused reads zero", rv, 0);
        end
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd1, rv); chk("R12 ctrl unchanged", rv, 32'h02);
        rd(3'd2, rv); chk("R12 baud unchanged", rv, 32'h5ABC);
        rd(3'd4, rv); chk("R12 flags unchanged", rv & 32'h3F, 32'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ctrl();
        t_baud();
        t_data();
        t_cmd_strobes();
        t_flags();
        t_set_wins();
        t_rdy_delay();
        t_cancel();
        t_trdy();
        t_irq();
        t_ro();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule